// File: doc/BRIEF.md
# Interrupt Queue and Dispatcher

This block buffers 16-bit interrupt messages for a small 16-bit processor core and decides when to deliver them. Messages arrive from attached hardware through a valid/ready port, or from the core's software-interrupt instruction. The queue is circular and its depth is a power-of-two parameter. Software requests win over hardware requests in the same cycle.

The core raises `boundary_i` once the current instruction and any instructions it skipped are finished. If interrupts are not deferred and the queue holds a message, the oldest message is removed. When the handler address is non-zero, the block runs a two-cycle push sequence on a single memory write port. The first cycle stores PC and the second stores A. In the second cycle the block also tells the core to load PC, A and SP. When the handler address is zero, the message is dropped.

The return-from-interrupt sequence reads two words back, A first and then PC, through a read port with one cycle of latency. A queue-enable command sets or clears the deferral flag directly. If the queue overflows, the block raises a sticky fault flag. The core holds off `boundary_i`, `qen_i` and `rfi_i` while `busy_o` is high, and raises at most one of them per cycle.

Top module: `irq_dispatch`

## Requirements
- R1: A software request (`swi_i`) enqueues `swi_msg_i` only when `ia_i` is non-zero. When it is accepted, `hw_ready_o` is low in that cycle and the hardware message is not taken. Otherwise a hardware request with `hw_valid_i` high is enqueued.
- R2: Messages are delivered in the order they were accepted. The value loaded into A during a dispatch is the oldest message still queued.
- R3: Overflow is an enqueue that would leave DEPTH messages outstanding, counted after any removal in the same cycle. On overflow, `enq_err_o` is high in that cycle and `fault_o` rises on the next edge and stays set until reset. All queued messages are lost.
- R4: A dispatch decision is made only in a cycle where the block is idle and `boundary_i` is high, the deferral flag is clear, and the queue is non-empty. In any other case no message is removed.
- R5: With a non-zero `ia_i`, the cycle after the decision writes the captured PC to address SP-1. The following cycle writes the captured A to SP-2 and loads PC with the captured IA, A with the message and SP with SP-2. The deferral flag is set from the cycle after the decision.
- R6: With `ia_i` zero at the decision, the oldest message is removed and dropped. There are no memory accesses, no register loads, and no change to the deferral flag.
- R7: `rfi_i` clears the deferral flag. It then reads address SP, then SP+1, in consecutive cycles. A is loaded from the first word in the cycle after the first read, and PC from the second word one cycle later, together with SP+2.
- R8: `qen_i` sets the deferral flag when `qen_arg_i` is non-zero and clears it when `qen_arg_i` is zero.
- R9: Reset clears the deferral flag, the fault flag and the queue. After reset no dispatch occurs until a new message is accepted.
- R10: `busy_o` is high in every cycle of a push or pop sequence and low otherwise. At most one of `mem_we_o` and `mem_re_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_valid_i | input | 1 | Hardware message valid |
| hw_msg_i | input | 16 | Hardware message |
| hw_ready_o | output | 1 | Hardware message accepted this cycle if valid |
| swi_i | input | 1 | Software-interrupt instruction executes |
| swi_msg_i | input | 16 | Software-interrupt operand |
| ia_i | input | 16 | Handler address register |
| pc_i | input | 16 | Core PC at the boundary |
| a_i | input | 16 | Core register A |
| sp_i | input | 16 | Core stack pointer |
| boundary_i | input | 1 | Instruction boundary reached |
| qen_i | input | 1 | Queue-enable instruction executes |
| qen_arg_i | input | 16 | Queue-enable operand |
| rfi_i | input | 1 | Return-from-interrupt instruction executes |
| rd_data_i | input | 16 | Memory read data, one cycle after `mem_re_o` |
| busy_o | output | 1 | Push or pop sequence in progress |
| deferred_o | output | 1 | Deferral flag |
| fault_o | output | 1 | Sticky overflow fault |
| enq_err_o | output | 1 | This cycle's enqueue overflowed |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| pc_ld_o | output | 1 | Load PC |
| pc_val_o | output | 16 | Value for PC |
| a_ld_o | output | 1 | Load A |
| a_val_o | output | 16 | Value for A |
| sp_ld_o | output | 1 | Load SP |
| sp_val_o | output | 16 | Value for SP |

## Verification
The bench aims at four corner cases.

- The wrap to exactly DEPTH outstanding messages. A design with an off-by-one full test would either raise the fault one message early or keep a stale queue that later dispatches messages that should have been lost.
- A software and a hardware request in the same cycle. Wrong priority would drop or reorder a message, and the reference queue would then disagree on the A value at the next dispatch.
- A zero handler address at the decision. A design that still pushed, or still set the deferral flag, would show writes or a stuck flag.
- The pop order. Reading PC before A, or loading A in the wrong cycle, would restore swapped values at the end of the return sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_A,
    ST_POP_A,
    ST_POP_PC,
    ST_POP_FIN
  } seq_st_e;
endpackage

// File: rtl/irq_fifo.sv
module irq_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enq_i,
  input  logic [W-1:0] enq_data_i,
  input  logic         deq_i,
  output logic [W-1:0] head_data_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     store_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q, head_nx, tail_inc;

  assign empty_o     = (head_q == tail_q);
  assign head_data_o = empty_o ? '0 : store_q[head_q];
  assign head_nx     = head_q + IDX_W'(deq_i && !empty_o);
  assign tail_inc    = tail_q + IDX_W'(1);
  // overflow: advanced tail meets the head as updated this cycle
  assign ovf_o       = enq_i && (tail_inc == head_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) store_q[i] <= '0;
    end else begin
      head_q <= head_nx;
      if (enq_i) begin
        store_q[tail_q] <= enq_data_i;
        tail_q          <= tail_inc;
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         boundary_i,
  input  logic         qen_i,
  input  logic [W-1:0] qen_arg_i,
  input  logic         rfi_i,
  input  logic [W-1:0] ia_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] rd_data_i,
  input  logic         empty_i,
  input  logic [W-1:0] msg_i,
  output logic         deq_o,
  output logic         busy_o,
  output logic         deferred_o,
  output logic         mem_we_o,
  output logic         mem_re_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         pc_ld_o,
  output logic [W-1:0] pc_val_o,
  output logic         a_ld_o,
  output logic [W-1:0] a_val_o,
  output logic         sp_ld_o,
  output logic [W-1:0] sp_val_o
);
  seq_st_e      st_q;
  logic         defer_q;
  logic [W-1:0] pc_q, a_q, sp_q, ia_q, msg_q;
  logic         idle, take_irq;

  assign idle       = (st_q == ST_IDLE);
  assign take_irq   = idle && boundary_i && !rfi_i && !qen_i && !defer_q && !empty_i;
  assign deq_o      = take_irq;
  assign busy_o     = !idle;
  assign deferred_o = defer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      defer_q <= 1'b0;
      pc_q    <= '0;
      a_q     <= '0;
      sp_q    <= '0;
      ia_q    <= '0;
      msg_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rfi_i) begin
            defer_q <= 1'b0;
            sp_q    <= sp_i;
            st_q    <= ST_POP_A;
          end else if (qen_i) begin
            defer_q <= |qen_arg_i;
          end else if (take_irq && |ia_i) begin
            defer_q <= 1'b1;
            pc_q    <= pc_i;
            a_q     <= a_i;
            sp_q    <= sp_i;
            ia_q    <= ia_i;
            msg_q   <= msg_i;
            st_q    <= ST_PUSH_PC;
          end
        end
        ST_PUSH_PC: st_q <= ST_PUSH_A;
        ST_PUSH_A:  st_q <= ST_IDLE;
        ST_POP_A:   st_q <= ST_POP_PC;
        ST_POP_PC:  st_q <= ST_POP_FIN;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    pc_ld_o     = 1'b0;
    pc_val_o    = '0;
    a_ld_o      = 1'b0;
    a_val_o     = '0;
    sp_ld_o     = 1'b0;
    sp_val_o    = '0;
    unique case (st_q)
      ST_PUSH_PC: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - W'(1);
        mem_wdata_o = pc_q;
      end
      ST_PUSH_A: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - W'(2);
        mem_wdata_o = a_q;
        pc_ld_o     = 1'b1;
        pc_val_o    = ia_q;
        a_ld_o      = 1'b1;
        a_val_o     = msg_q;
        sp_ld_o     = 1'b1;
        sp_val_o    = sp_q - W'(2);
      end
      ST_POP_A: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_q;
      end
      ST_POP_PC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_q + W'(1);
        a_ld_o     = 1'b1;
        a_val_o    = rd_data_i;
      end
      ST_POP_FIN: begin
        pc_ld_o  = 1'b1;
        pc_val_o = rd_data_i;
        sp_ld_o  = 1'b1;
        sp_val_o = sp_q + W'(2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_valid_i,
  input  logic [WORD_W-1:0]   hw_msg_i,
  output logic                hw_ready_o,
  input  logic                swi_i,
  input  logic [WORD_W-1:0]   swi_msg_i,
  input  logic [WORD_W-1:0]   ia_i,
  input  logic [WORD_W-1:0]   pc_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   sp_i,
  input  logic                boundary_i,
  input  logic                qen_i,
  input  logic [WORD_W-1:0]   qen_arg_i,
  input  logic                rfi_i,
  input  logic [WORD_W-1:0]   rd_data_i,
  output logic                busy_o,
  output logic                deferred_o,
  output logic                fault_o,
  output logic                enq_err_o,
  output logic                mem_we_o,
  output logic                mem_re_o,
  output logic [WORD_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic                pc_ld_o,
  output logic [WORD_W-1:0]   pc_val_o,
  output logic                a_ld_o,
  output logic [WORD_W-1:0]   a_val_o,
  output logic                sp_ld_o,
  output logic [WORD_W-1:0]   sp_val_o
);
  logic              sw_acc, enq, deq, empty, ovf, fault_q;
  logic [WORD_W-1:0] enq_data, head_msg;

  // software request wins the single enqueue slot
  assign sw_acc     = swi_i && (ia_i != '0);
  assign hw_ready_o = !sw_acc;
  assign enq        = sw_acc || hw_valid_i;
  assign enq_data   = sw_acc ? swi_msg_i : hw_msg_i;
  assign enq_err_o  = ovf;
  assign fault_o    = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  fault_q <= 1'b0;
    else if (ovf) fault_q <= 1'b1;
  end

  irq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_i       (enq),
    .enq_data_i  (enq_data),
    .deq_i       (deq),
    .head_data_o (head_msg),
    .empty_o     (empty),
    .ovf_o       (ovf)
  );

  irq_seq #(.W(WORD_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .qen_i       (qen_i),
    .qen_arg_i   (qen_arg_i),
    .rfi_i       (rfi_i),
    .ia_i        (ia_i),
    .pc_i        (pc_i),
    .a_i         (a_i),
    .sp_i        (sp_i),
    .rd_data_i   (rd_data_i),
    .empty_i     (empty),
    .msg_i       (head_msg),
    .deq_o       (deq),
    .busy_o      (busy_o),
    .deferred_o  (deferred_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_ld_o     (pc_ld_o),
    .pc_val_o    (pc_val_o),
    .a_ld_o      (a_ld_o),
    .a_val_o     (a_val_o),
    .sp_ld_o     (sp_ld_o),
    .sp_val_o    (sp_val_o)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rfi_i,
  input logic        qen_i,
  input logic [15:0] qen_arg_i,
  input logic        busy_o,
  input logic        deferred_o,
  input logic        fault_o,
  input logic        enq_err_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] mem_addr_o,
  input logic        pc_ld_o,
  input logic        a_ld_o,
  input logic        sp_ld_o
);
  p_fault_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  p_err_sets_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_err_o |=> fault_o);

  p_push_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !pc_ld_o) |=> (mem_we_o && pc_ld_o && a_ld_o && sp_ld_o));

  p_push_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !pc_ld_o) |=> (mem_addr_o == $past(mem_addr_o) - 16'd1));

  p_push_deferred_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> deferred_o);

  p_pop_seq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !a_ld_o) |=> (mem_re_o && a_ld_o && mem_addr_o == $past(mem_addr_o) + 16'd1));

  p_rfi_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !busy_o) |=> !deferred_o);

  p_qen_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qen_i && !rfi_i && !busy_o && qen_arg_i != 16'd0) |=> deferred_o);

  p_one_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o}));

  p_busy_on_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);
endmodule

bind irq_dispatch irq_dispatch_chk i_chk (.*);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0, swi = 1'b0, boundary = 1'b0, qen = 1'b0, rfi = 1'b0;
  logic [15:0] hw_msg = '0, swi_msg = '0, ia = '0, pc = '0, a = '0, sp = '0, qen_arg = '0;
  logic [15:0] rd_data = '0;
  logic        hw_ready, busy, deferred, fault, enq_err, mem_we, mem_re, pc_ld, a_ld, sp_ld;
  logic [15:0] mem_addr, mem_wdata, pc_val, a_val, sp_val;

  always #5 clk = ~clk;

  irq_dispatch #(.DEPTH(DEPTH)) i_irq_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .hw_valid_i(hw_valid), .hw_msg_i(hw_msg), .hw_ready_o(hw_ready),
    .swi_i(swi), .swi_msg_i(swi_msg), .ia_i(ia), .pc_i(pc), .a_i(a), .sp_i(sp),
    .boundary_i(boundary), .qen_i(qen), .qen_arg_i(qen_arg), .rfi_i(rfi),
    .rd_data_i(rd_data), .busy_o(busy), .deferred_o(deferred), .fault_o(fault),
    .enq_err_o(enq_err), .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .pc_ld_o(pc_ld), .pc_val_o(pc_val), .a_ld_o(a_ld),
    .a_val_o(a_val), .sp_ld_o(sp_ld), .sp_val_o(sp_val)
  );

  // memory seen by the block
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_re) rd_data <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
  end

  int checks = 0, fails = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] q [$];
  bit          m_defer, m_fault;
  int          phase;   // 0 idle, 1..2 push, 3..5 pop
  logic [15:0] c_pc, c_a, c_sp, c_ia, c_msg;

  task automatic model_reset();
    q.delete();
    m_defer = 0; m_fault = 0; phase = 0;
    c_pc = 0; c_a = 0; c_sp = 0; c_ia = 0; c_msg = 0;
  endtask

  task automatic compare_and_update();
    bit          sw_acc, enq, deq, err;
    logic [15:0] e_we, e_re, e_addr, e_wd, e_pl, e_pv, e_al, e_av, e_sl, e_sv, m;
    sw_acc = swi && (ia != 0);
    enq    = sw_acc || hw_valid;
    deq    = (phase == 0) && boundary && !rfi && !qen && !m_defer && (q.size() > 0);
    err    = enq && ((q.size() - int'(deq) + 1) == DEPTH);
    {e_we, e_re, e_addr, e_wd, e_pl, e_pv, e_al, e_av, e_sl, e_sv} = '0;
    case (phase)
      1: begin e_we = 1; e_addr = c_sp - 16'd1; e_wd = c_pc; end
      2: begin e_we = 1; e_addr = c_sp - 16'd2; e_wd = c_a; e_pl = 1; e_pv = c_ia;
               e_al = 1; e_av = c_msg; e_sl = 1; e_sv = c_sp - 16'd2; end
      3: begin e_re = 1; e_addr = c_sp; end
      4: begin e_re = 1; e_addr = c_sp + 16'd1; e_al = 1; e_av = rd_data; end
      5: begin e_pl = 1; e_pv = rd_data; e_sl = 1; e_sv = c_sp + 16'd2; end
      default: ;
    endcase
    chk("R1 hw_ready", 16'(hw_ready), 16'(!sw_acc));
    chk("R3 enq_err", 16'(enq_err), 16'(err));
    chk("R3 fault", 16'(fault), 16'(m_fault));
    chk("R8 deferred", 16'(deferred), 16'(m_defer));
    chk("R10 busy", 16'(busy), 16'(phase != 0));
    chk("R5 mem_we", 16'(mem_we), e_we);
    chk("R7 mem_re", 16'(mem_re), e_re);
    chk("R5 mem_addr", mem_addr, e_addr);
    chk("R5 mem_wdata", mem_wdata, e_wd);
    chk("R4 pc_ld", 16'(pc_ld), e_pl);
    chk("R5 pc_val", pc_val, e_pv);
    chk("R4 a_ld", 16'(a_ld), e_al);
    chk(phase == 2 ? "R2 a_val" : "R7 a_val", a_val, e_av);
    chk("R4 sp_ld", 16'(sp_ld), e_sl);
    chk("R5 sp_val", sp_val, e_sv);
    // next state
    case (phase)
      0: begin
        if (rfi) begin m_defer = 0; c_sp = sp; phase = 3; end
        else if (qen) m_defer = (qen_arg != 0);
        else if (deq) begin
          m = q.pop_front();
          if (ia != 0) begin
            m_defer = 1; c_pc = pc; c_a = a; c_sp = sp; c_ia = ia; c_msg = m; phase = 1;
          end
        end
      end
      1: phase = 2;
      3: phase = 4;
      4: phase = 5;
      default: phase = 0;
    endcase
    if (enq) q.push_back(sw_acc ? swi_msg : hw_msg);
    if (err) begin m_fault = 1; q.delete(); end
  endtask

  task automatic step();
    #1;
    if (rst_n) compare_and_update();
    @(negedge clk);
    hw_valid = 0; swi = 0; boundary = 0; qen = 0; rfi = 0;
  endtask

  task automatic wait_idle();
    while (phase != 0) step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    #1;
    chk("R9 reset busy", 16'(busy), 16'd0);
    chk("R9 reset deferred", 16'(deferred), 16'd0);
    chk("R9 reset fault", 16'(fault), 16'd0);
    step();

    // R1: software request ignored with zero handler address
    ia = 16'h0000; swi = 1; swi_msg = 16'hdead; step();
    ia = 16'h0400; boundary = 1; step();
    #1; chk("R1 swi ignored when IA zero", 16'(busy), 16'd0);
    step();

    // fill: 11, 22, then sw 33 colliding with hw 44, then hw 44 retried
    sp = 16'h8000; pc = 16'h0100; a = 16'haaaa;
    hw_valid = 1; hw_msg = 16'h0011; step();
    hw_valid = 1; hw_msg = 16'h0022; step();
    swi = 1; swi_msg = 16'h0033; hw_valid = 1; hw_msg = 16'h0044; step();
    hw_valid = 1; hw_msg = 16'h0044; step();

    // R5: dispatch of 11
    boundary = 1; step(); wait_idle();
    chk("R5 pushed PC", ram[32'h7fff], 16'h0100);
    chk("R5 pushed A", ram[32'h7ffe], 16'haaaa);
    // R4: deferred, boundary does nothing
    boundary = 1; step();
    #1; chk("R4 no dispatch while deferred", 16'(busy), 16'd0);
    step();
    // R7: return restores A then PC
    sp = 16'h7ffe; rfi = 1; step(); wait_idle();
    // R8: enable/disable queueing
    qen = 1; qen_arg = 16'h0005; step();
    boundary = 1; step();
    qen = 1; qen_arg = 16'h0000; step();
    sp = 16'h9000; pc = 16'h0200; a = 16'h5555;
    boundary = 1; step(); wait_idle();   // dispatches 22
    sp = 16'h8ffe; rfi = 1; step(); wait_idle();
    // R6: zero handler address drops 33
    ia = 16'h0000; boundary = 1; step();
    #1; chk("R6 dropped, no sequence", 16'(busy), 16'd0);
    chk("R6 dropped, flag clear", 16'(deferred), 16'd0);
    step();
    ia = 16'h0400; boundary = 1; step(); wait_idle();   // dispatches 44 (R2)
    sp = 16'h8ffe; rfi = 1; step(); wait_idle();

    // R3: overflow with queueing enabled
    qen = 1; qen_arg = 16'h0001; step();
    for (int i = 0; i < DEPTH; i++) begin
      hw_valid = 1; hw_msg = 16'(i + 16'h1000); step();
    end
    #1; chk("R3 fault raised", 16'(fault), 16'd1);
    step();
    qen = 1; qen_arg = 16'h0000; step();
    boundary = 1; step();
    #1; chk("R3 queue lost after overflow", 16'(busy), 16'd0);
    step();
    hw_valid = 1; hw_msg = 16'h0077; step();
    #1; chk("R3 fault sticky", 16'(fault), 16'd1);
    step();

    // R9: reset drops queued messages and the fault
    do_reset();
    #1; chk("R9 fault cleared", 16'(fault), 16'd0);
    boundary = 1; step();
    #1; chk("R9 queue empty after reset", 16'(busy), 16'd0);
    step();

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      hw_valid = ($urandom_range(0, 99) < 35);
      hw_msg   = 16'($urandom());
      swi      = ($urandom_range(0, 99) < 10);
      swi_msg  = 16'($urandom());
      ia       = ($urandom_range(0, 9) == 0) ? 16'h0000 : 16'($urandom());
      pc = 16'($urandom()); a = 16'($urandom()); sp = 16'($urandom());
      if (phase == 0) begin
        if (r < 30) boundary = 1;
        else if (r < 38) rfi = 1;
        else if (r < 44) begin qen = 1; qen_arg = ($urandom_range(0, 1) == 1) ? 16'($urandom()) : 16'h0; end
      end
      step();
    end

    summary();
    $finish;
  end
endmodule